// File: doc/BRIEF.md
# Clock-Configuration Serial Register Slave

This block is a two-wire serial slave that holds the configuration bytes of a clock-synthesis controller. It receives SCL and SDA after they have been synchronised to a fast system clock, and it oversamples them. It finds start and stop conditions and decodes a 7-bit device address with a direction bit. It then runs byte-oriented block writes or block reads. It pulls SDA low through an output-enable for acknowledges and for read data. The stored bytes are presented in parallel to the rest of the chip on one flat bus.

A write transfer carries two leading bytes, a command code and a byte count. Both are acknowledged and thrown away, and the bytes that follow fill the register file from index 0 upward. A read transfer first returns a length byte, which is the value of the read-length register (index 7). It then returns registers from index 0 upward. The length register decides which register is the last one returned.

The other blocks of the chip read the configuration through `cfg_bytes`. Nothing else in the chip writes it.

Top module: `clkcfg_twi_slave`

## Requirements
- R1: The slave acknowledges address byte D2h (7-bit address 69h, write) and D3h (read). For any other address it leaves SDA released for the address byte and for every bit up to the next start condition.
- R2: In a write, the first two bytes after the address are acknowledged and change no register.
- R3: Each later write byte is acknowledged and stored at register 0, then 1, then 2, and so on in ascending order.
- R4: Write bytes after register 20 has been written are acknowledged and change no register.
- R5: A read returns the read-length register (index 7) as its first byte, then register 0, 1, 2 and so on.
- R6: The last register a read returns has index min(length, 20). Any byte the master clocks after it reads FFh.
- R7: The read-length register resets to 08h. A write of 00h to it leaves its previous value in place.
- R8: Register 11 always reads 1001b in bits 7:4 and resets to 90h. Only bits 3:0 take written data.
- R9: A stop condition, or a NACK from the master after a read byte, returns the slave to idle. SDA stays released until the next start.
- R10: A repeated start restarts address decoding at once and leaves the register contents intact.
- R11: After reset, SDA is released, every register other than 7 and 11 holds 00h, and the SDA drive changes only while SCL is low.
- R12: Register i appears on `cfg_bytes[8*i+7:8*i]` and updates within one system clock of the acknowledge edge of the byte that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronised serial clock from the bus |
| sda_in | input | 1 | Synchronised serial data from the bus (wired-AND value) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_bytes | output | 168 | Parallel register file, register i at bits 8*i+7:8*i |

## Verification
A wrong state inside the block shows up on the bus no more than one SCL period later. An address or phase error turns into a missing or stray acknowledge at the ninth clock of the current byte. A pointer or length error turns into a wrong byte, or a wrong FFh, in the first read that reaches that register. A wrong write path shows on `cfg_bytes` one system clock after the acknowledge edge of the byte that caused it. The bench therefore compares every acknowledge bit, every byte read back and the whole parallel register file after each transfer. A separate monitor flags any change of the SDA drive while SCL is high.

// File: rtl/clkcfg_pkg.sv
// Package: shared types and defaults for the clock-configuration serial slave.
// Assumes: all users import it; nothing here is synthesised on its own.
package clkcfg_pkg;

    // Protocol states of the byte engine
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_RX,     // shifting in an address or a write byte
        ST_ACK,    // holding SDA low for our acknowledge
        ST_TX,     // shifting out a read byte
        ST_TXACK   // released, sampling the master's acknowledge
    } twi_state_e;

    localparam int         DEF_NUM_REGS  = 21;
    localparam logic [6:0] DEF_DEV_ADDR  = 7'h69;
    localparam int         DEF_LEN_IDX   = 7;
    localparam logic [7:0] DEF_LEN_RESET = 8'h08;
    localparam int         DEF_ID_IDX    = 11;
    localparam logic [3:0] DEF_ID_NIBBLE = 4'b1001;

endpackage

// File: rtl/clkcfg_twi_linemon.sv
// Module: line monitor. Delays SCL/SDA by one system clock and flags
// SCL edges and start/stop conditions.
// Assumes: inputs are already synchronised. SDA changes only while SCL is
// low, except for start and stop conditions.
module clkcfg_twi_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Keep the previous level of both lines (the bus idles high)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Edge and condition flags, valid for one system clock
    always_comb begin
        scl_rise  = scl_in & ~scl_q;
        scl_fall  = ~scl_in & scl_q;
        start_det = scl_in & scl_q & sda_q & ~sda_in;
        stop_det  = scl_in & scl_q & ~sda_q & sda_in;
    end

endmodule

// File: rtl/clkcfg_regbank.sv
// Module: configuration register file. Holds NUM_REGS bytes and exposes
// them in parallel. It also gives one combinational read port and the
// read-length value.
// Assumes: at most one write per clock. An address at or above NUM_REGS
// reads FFh.
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int         NUM_REGS  = DEF_NUM_REGS,
    parameter int         LEN_IDX   = DEF_LEN_IDX,
    parameter logic [7:0] LEN_RESET = DEF_LEN_RESET,
    parameter int         ID_IDX    = DEF_ID_IDX,
    parameter logic [3:0] ID_NIBBLE = DEF_ID_NIBBLE,
    parameter int         PTR_W     = $clog2(NUM_REGS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [7:0]            rd_data,
    output logic [7:0]            len_val,
    output logic [NUM_REGS*8-1:0] cfg_bytes
);

    localparam int LEN_LSB = 8 * LEN_IDX;
    localparam int ID_LSB  = 8 * ID_IDX;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic [7:0] q;
        logic       hit;
        assign hit = wr_en && (wr_addr == PTR_W'(gi));

        if (gi == LEN_IDX) begin : g_len
            // Read-length register: a write of zero is refused
            always_ff @(posedge clk) begin
                if (!rst_n)                        q <= LEN_RESET;
                else if (hit && (wr_data != 8'h00)) q <= wr_data;
            end
        end else if (gi == ID_IDX) begin : g_id
            // Identification register: the upper nibble is fixed
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= {ID_NIBBLE, 4'h0};
                else if (hit) q <= {ID_NIBBLE, wr_data[3:0]};
            end
        end else begin : g_plain
            // Plain configuration byte
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= 8'h00;
                else if (hit) q <= wr_data;
            end
        end

        assign cfg_bytes[8*gi +: 8] = q;
    end

    // Read multiplexer; an out-of-range address returns all ones
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == PTR_W'(i)) rd_data = cfg_bytes[8*i +: 8];
        end
    end

    assign len_val = cfg_bytes[LEN_LSB +: 8];

    // R7: a zero written to the length register must not land
    a_r7_zero_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PTR_W'(LEN_IDX) && wr_data == 8'h00)
        |=> (cfg_bytes[LEN_LSB +: 8] == $past(cfg_bytes[LEN_LSB +: 8])));

    // R8: identification nibble survives any write to its register
    a_r8_id_nibble_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PTR_W'(ID_IDX))
        |=> (cfg_bytes[ID_LSB+4 +: 4] == ID_NIBBLE));

    // R3: a write to a plain register stores the written byte
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PTR_W'(0))
        |=> (cfg_bytes[7:0] == $past(wr_data)));

endmodule

// File: rtl/clkcfg_twi_engine.sv
// Module: byte engine. Shifts the address and data bytes, produces
// acknowledges and read data on SDA, and steers the register pointer.
// Assumes: SCL stays low and high for several system clocks each. Start
// and stop flags come from the line monitor. No clock stretching.
module clkcfg_twi_engine
    import clkcfg_pkg::*;
#(
    parameter int         NUM_REGS = DEF_NUM_REGS,
    parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR,
    parameter int         PTR_W    = $clog2(NUM_REGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       len_val,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] rd_addr,
    output logic             sda_oe
);

    localparam logic [7:0]       LAST_MAX = 8'(NUM_REGS - 1);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(NUM_REGS);

    twi_state_e       state;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [2:0]       bitcnt;
    logic             byte_full;
    logic             addr_phase;
    logic             is_read;
    logic [1:0]       wr_stage;
    logic [PTR_W-1:0] ptr;
    logic             rd_first;
    logic             master_ack;
    logic             drive_q;
    logic [7:0]       eff_last;
    logic [7:0]       tx_next;
    logic             data_done;

    // Last register a read returns: the length value capped at the top index
    always_comb eff_last = (len_val > LAST_MAX) ? LAST_MAX : len_val;

    // Next byte to transmit: length byte first, then registers, then filler
    always_comb begin
        if (rd_first)                    tx_next = len_val;
        else if (8'(ptr) <= eff_last)    tx_next = rd_data;
        else                             tx_next = 8'hFF;
    end

    // A full write byte is complete at this SCL falling edge
    always_comb data_done = (state == ST_RX) && scl_fall && byte_full && !addr_phase;

    // Write strobe, only for data bytes that still fit in the file
    always_comb begin
        wr_en   = data_done && (wr_stage == 2'd2) && (ptr < PTR_END);
        wr_addr = ptr;
        wr_data = rx_sh;
        rd_addr = ptr;
    end

    assign sda_oe = drive_q;

    // Protocol sequencer: conditions first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            rx_sh      <= 8'h00;
            tx_sh      <= 8'hFF;
            bitcnt     <= 3'd0;
            byte_full  <= 1'b0;
            addr_phase <= 1'b0;
            is_read    <= 1'b0;
            wr_stage   <= 2'd0;
            ptr        <= '0;
            rd_first   <= 1'b0;
            master_ack <= 1'b0;
            drive_q    <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            drive_q <= 1'b0;
        end else if (start_det) begin
            state      <= ST_RX;
            addr_phase <= 1'b1;
            bitcnt     <= 3'd0;
            byte_full  <= 1'b0;
            drive_q    <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], sda_in};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) byte_full <= 1'b1;
                    end else if (scl_fall && byte_full) begin
                        byte_full <= 1'b0;
                        if (addr_phase) begin
                            addr_phase <= 1'b0;
                            if (rx_sh[7:1] == DEV_ADDR) begin
                                is_read  <= rx_sh[0];
                                wr_stage <= 2'd0;
                                ptr      <= '0;
                                rd_first <= 1'b1;
                                drive_q  <= 1'b1;
                                state    <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            if (wr_stage != 2'd2)   wr_stage <= wr_stage + 2'd1;
                            else if (ptr < PTR_END) ptr <= ptr + 1'b1;
                            drive_q <= 1'b1;
                            state   <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= 3'd0;
                        if (is_read) begin
                            tx_sh   <= tx_next;
                            drive_q <= ~tx_next[7];
                            if (rd_first)           rd_first <= 1'b0;
                            else if (ptr < PTR_END) ptr <= ptr + 1'b1;
                            state <= ST_TX;
                        end else begin
                            drive_q <= 1'b0;
                            state   <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            drive_q <= 1'b0;
                            state   <= ST_TXACK;
                        end else begin
                            tx_sh   <= {tx_sh[6:0], 1'b1};
                            drive_q <= ~tx_sh[6];
                            bitcnt  <= bitcnt + 3'd1;
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_in;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            tx_sh   <= tx_next;
                            drive_q <= ~tx_next[7];
                            bitcnt  <= 3'd0;
                            if (rd_first)           rd_first <= 1'b0;
                            else if (ptr < PTR_END) ptr <= ptr + 1'b1;
                            state <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    drive_q <= 1'b0;
                end
            endcase
        end
    end

    // R11: the SDA drive only changes while SCL is low
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_q) |-> !scl_in);

    // R9: a stop condition leaves the engine idle with SDA released
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_oe);

    // R9: a master NACK after a read byte releases the bus
    a_r9_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TXACK && scl_fall && !master_ack && !start_det && !stop_det)
        |=> (state == ST_IDLE) && !sda_oe);

    // R1: in idle the slave never pulls SDA
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R10: a start condition always restarts address decoding
    a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_RX) && addr_phase);

    // R4: the pointer never passes one beyond the last register
    a_r4_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_END);

endmodule

// File: rtl/clkcfg_twi_slave.sv
// Module: top of the clock-configuration serial slave. Connects the line
// monitor, the byte engine and the register file.
// Assumes: scl_in/sda_in are synchronised to clk. The pad pulls SDA low
// whenever sda_oe is 1.
module clkcfg_twi_slave
    import clkcfg_pkg::*;
#(
    parameter int         NUM_REGS  = DEF_NUM_REGS,
    parameter logic [6:0] DEV_ADDR  = DEF_DEV_ADDR,
    parameter int         LEN_IDX   = DEF_LEN_IDX,
    parameter logic [7:0] LEN_RESET = DEF_LEN_RESET,
    parameter int         ID_IDX    = DEF_ID_IDX,
    parameter logic [3:0] ID_NIBBLE = DEF_ID_NIBBLE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_bytes
);

    localparam int PTR_W = $clog2(NUM_REGS + 1);

    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [PTR_W-1:0] rd_addr;
    logic [7:0]       rd_data;
    logic [7:0]       len_val;

    clkcfg_twi_linemon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkcfg_twi_engine #(
        .NUM_REGS (NUM_REGS),
        .DEV_ADDR (DEV_ADDR),
        .PTR_W    (PTR_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .len_val   (len_val),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .sda_oe    (sda_oe)
    );

    clkcfg_regbank #(
        .NUM_REGS  (NUM_REGS),
        .LEN_IDX   (LEN_IDX),
        .LEN_RESET (LEN_RESET),
        .ID_IDX    (ID_IDX),
        .ID_NIBBLE (ID_NIBBLE),
        .PTR_W     (PTR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .len_val   (len_val),
        .cfg_bytes (cfg_bytes)
    );

endmodule

// File: tb/clkcfg_twi_slave_test.sv
// Bench: models a two-wire master, keeps its own model of the register file
// and sweeps addresses, write lengths and read-length values.
module clkcfg_twi_slave_test;

    localparam int Q  = 6;
    localparam int NR = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          sda_oe;
    logic          sda_bus;
    logic [NR*8-1:0] cfg_bytes;

    int n_cmp = 0;
    int n_bad = 0;
    int viol  = 0;
    logic oe_prev = 1'b0;

    logic [7:0] exp_r [0:NR-1];
    logic [7:0] wbuf  [0:23];

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    clkcfg_twi_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .cfg_bytes (cfg_bytes)
    );

    // R11 monitor: the drive must not change while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && m_scl) viol <= viol + 1;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic qwait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b0; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b1; qwait;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qwait;
            m_scl = 1'b1; qwait; qwait;
            m_scl = 1'b0; qwait;
        end
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        acked = ~sda_bus; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait;
            m_scl = 1'b1; qwait;
            b[i] = sda_bus; qwait;
            m_scl = 1'b0;
        end
        qwait;
        m_sda = ~give_ack; qwait;
        m_scl = 1'b1; qwait; qwait;
        m_scl = 1'b0; qwait;
        m_sda = 1'b1;
    endtask

    // Model of one register write, taken from R3, R7 and R8
    task automatic model_wr(input int idx, input logic [7:0] v);
        if (idx == 7) begin
            if (v != 8'h00) exp_r[idx] = v;
        end else if (idx == 11) begin
            exp_r[idx] = {4'b1001, v[3:0]};
        end else if (idx < NR) begin
            exp_r[idx] = v;
        end
    endtask

    function automatic logic [7:0] rd_expect(input int idx);
        int last;
        last = (exp_r[7] > 8'd20) ? 20 : int'(exp_r[7]);
        return (idx <= last) ? exp_r[idx] : 8'hFF;
    endfunction

    task automatic check_regs(input string tag);
        for (int i = 0; i < NR; i++) chk(tag, 32'(cfg_bytes[8*i +: 8]), 32'(exp_r[i]));
    endtask

    // Full write transfer: address, two dummy bytes, then n data bytes
    task automatic do_write(input int n);
        logic a;
        bus_start;
        send_byte(8'hD2, a);  chk("R1 write address ack", 32'(a), 32'd1);
        send_byte(8'hE7, a);  chk("R2 command byte ack", 32'(a), 32'd1);
        send_byte(8'h3C, a);  chk("R2 count byte ack", 32'(a), 32'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            if (i < NR) chk("R3 data byte ack", 32'(a), 32'd1);
            else        chk("R4 overflow byte ack", 32'(a), 32'd1);
            model_wr(i, wbuf[i]);
        end
        bus_stop;
        qwait;
        check_regs("R12 register file after write");
    endtask

    // Read transfer of nbytes (length byte included); last byte NACKed
    task automatic do_read(input int nbytes);
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte(8'hD3, a); chk("R1 read address ack", 32'(a), 32'd1);
        for (int j = 0; j < nbytes; j++) begin
            recv_byte(j != nbytes - 1, b);
            if (j == 0) chk("R5 length byte", 32'(b), 32'(exp_r[7]));
            else        chk("R6 read byte sequence", 32'(b), 32'(rd_expect(j - 1)));
        end
        qwait;
        chk("R9 released after NACK", 32'(sda_oe), 32'd0);
        bus_stop;
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        logic [7:0] lens [0:5];

        for (int i = 0; i < NR; i++) exp_r[i] = 8'h00;
        exp_r[7]  = 8'h08;
        exp_r[11] = 8'h90;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        qwait;

        // R11, R7, R8 reset state
        chk("R11 SDA released after reset", 32'(sda_oe), 32'd0);
        check_regs("R11 R7 R8 reset values");

        // R1: sweep of foreign addresses in both directions
        for (int ad = 0; ad < 128; ad += 9) begin
            for (int d = 0; d < 2; d++) begin
                bus_start;
                send_byte({7'(ad), 1'(d)}, a); chk("R1 foreign address nack", 32'(a), 32'd0);
                send_byte(8'h00, a);           chk("R1 follow-on byte ignored", 32'(a), 32'd0);
                bus_stop;
            end
        end
        foreach (lens[k]) lens[k] = 8'h00;
        lens[0] = 8'hD0; lens[1] = 8'hD4; lens[2] = 8'h52; lens[3] = 8'hD1;
        for (int k = 0; k < 4; k++) begin
            bus_start;
            send_byte(lens[k], a); chk("R1 near-miss address nack", 32'(a), 32'd0);
            send_byte(8'h00, a);   chk("R1 near-miss follow-on ignored", 32'(a), 32'd0);
            bus_stop;
        end
        check_regs("R1 registers untouched by foreign traffic");

        // R2: only the two dummy bytes, nothing stored
        do_write(0);

        // R3, R4, R8: fill every register and overrun by two
        for (int i = 0; i < 24; i++) wbuf[i] = 8'((i * 37 + 11) & 8'hFF);
        do_write(23);

        // R5, R6: read with the current length plus two filler bytes
        do_read(int'(exp_r[7]) + 4);

        // R6: sweep of read-length values, including one above the top index
        lens[0] = 8'h01; lens[1] = 8'h07; lens[2] = 8'h12;
        lens[3] = 8'h13; lens[4] = 8'h14; lens[5] = 8'h1F;
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 7; i++) wbuf[i] = exp_r[i] ^ 8'(k + 1);
            wbuf[7] = lens[k];
            do_write(8);
            do_read(((lens[k] > 8'd20) ? 20 : int'(lens[k])) + 3);
        end

        // R7: zero write to the length register is refused
        for (int i = 0; i < 7; i++) wbuf[i] = exp_r[i];
        wbuf[7] = 8'h00;
        do_write(8);
        chk("R7 length kept after zero write", 32'(cfg_bytes[8*7 +: 8]), 32'(exp_r[7]));
        do_read(3);

        // R9: stop straight after the command byte
        bus_start;
        send_byte(8'hD2, a); chk("R9 address ack before stop", 32'(a), 32'd1);
        send_byte(8'h55, a); chk("R9 command ack before stop", 32'(a), 32'd1);
        bus_stop;
        qwait;
        chk("R9 released after stop", 32'(sda_oe), 32'd0);
        check_regs("R9 registers unchanged by aborted write");

        // R9: NACK mid-read, further clocking sees a released bus
        bus_start;
        send_byte(8'hD3, a); chk("R9 read address ack", 32'(a), 32'd1);
        recv_byte(1'b1, b);  chk("R5 length byte before nack", 32'(b), 32'(exp_r[7]));
        recv_byte(1'b0, b);  chk("R5 register 0 before nack", 32'(b), 32'(exp_r[0]));
        recv_byte(1'b0, b);  chk("R9 idle after master NACK", 32'(b), 32'hFF);
        bus_stop;

        // R10: write, repeated start, read back without a stop in between
        bus_start;
        send_byte(8'hD2, a); chk("R10 write address ack", 32'(a), 32'd1);
        send_byte(8'h01, a); chk("R10 command ack", 32'(a), 32'd1);
        send_byte(8'h02, a); chk("R10 count ack", 32'(a), 32'd1);
        send_byte(8'h5A, a); chk("R10 reg0 ack", 32'(a), 32'd1); model_wr(0, 8'h5A);
        send_byte(8'hC3, a); chk("R10 reg1 ack", 32'(a), 32'd1); model_wr(1, 8'hC3);
        bus_start;
        send_byte(8'hD3, a); chk("R10 read address after repeated start", 32'(a), 32'd1);
        recv_byte(1'b1, b);  chk("R10 length byte", 32'(b), 32'(exp_r[7]));
        recv_byte(1'b1, b);  chk("R10 reg0 readback", 32'(b), 32'h5A);
        recv_byte(1'b0, b);  chk("R10 reg1 readback", 32'(b), 32'hC3);
        bus_stop;
        qwait;
        check_regs("R10 register file intact");

        chk("R11 no SDA change while SCL high", 32'(viol), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule